// File: doc/BRIEF.md
# Pseudo-Mersenne Residue Arithmetic Unit

This block performs one modular operation per cycle (addition, subtraction or multiplication) on a single residue channel. The modulus sits just below a power of two: m = 2^W − d, where the distance d is small and is supplied with every operation. Both operands must already be reduced below m. The result is returned fully reduced below m. The block is meant as the per-lane arithmetic cell of a residue-number datapath. Many copies run side by side, each with its own d.

Multiplication avoids a general divider. It uses the congruence 2^W ≡ d (mod m) to fold the high word of the double-width product back into the low word twice, with small multiplies by d. A final select among three candidates (s, s − m, s − 2m) finishes the reduction. Addition and subtraction work the same way: every candidate is computed on every operation, and one is selected at the end.

The pipeline has two register stages and the same latency for every opcode. The input side is a plain valid strobe and the output side is a plain valid flag. There is no ready signal and no back-pressure: an operation is accepted in every cycle that `in_valid` is high, and the consumer must take each result in the cycle it appears.

Top module: `pmr_unit`

## Requirements
- R1: While `rst_n` is low, and after reset until the first result, `out_valid` is 0 and `out_data` is 0.
- R2: An operation presented with `in_valid` high at rising edge k appears with `out_valid` high after rising edge k+2. This holds for every opcode, with exactly one result per accepted operation.
- R3: Opcode 2'b00 returns (a + b) mod m.
- R4: Opcode 2'b01 returns (a − b) mod m, including the wrap case a < b.
- R5: Opcode 2'b10 returns (a · b) mod m for every pair of legal operands, including a = b = m − 1.
- R6: For operands below m, every result is strictly below m.
- R7: Only bit 1 of the opcode selects multiplication, so opcode 2'b11 behaves exactly like 2'b10.
- R8: The modulus is m = 2^W − d, with `in_d` in 1..65534 (for the default width). `in_d` is sampled together with the operands, so a change of d between back-to-back operations applies per operation.
- R9: Operations issued in consecutive cycles produce results in consecutive cycles, in issue order.
- R10: A cycle with `in_valid` low produces a cycle with `out_valid` low two edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation strobe; no ready signal |
| in_op | input | 2 | 00 add, 01 subtract, 1x multiply |
| in_a | input | W (32) | First operand, below m |
| in_b | input | W (32) | Second operand, below m |
| in_d | input | DW (16) | Distance of the modulus below 2^W |
| out_valid | output | 1 | Result strobe, two edges after the operation |
| out_data | output | W (32) | Result, reduced below m |

## Verification
The operands m − 1 and 0 stress the final selection of each opcode:
- (m − 1) + (m − 1) and 0 − (m − 1) force the correction path.
- (m − 1)² yields the largest folded sums.

Identity operands (add 0, multiply by 1, a − a) show whether a correction is applied when none is due. Random operands run under several d values, from 1 up to 65534, where the second fold's contribution is largest. Interleaved idle cycles, back-to-back bursts, the 2'b11 opcode alias and d switching between consecutive operations separate ordering, latency and per-operation modulus faults from arithmetic faults.

// File: rtl/pmr_pkg.sv
package pmr_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_MUL  = 2'b10,
    OP_MULX = 2'b11
  } pmr_op_e;
endpackage

// File: rtl/pmr_prep.sv
// Stage-1 combinational work: both add/sub candidates and the full product.
module pmr_prep #(
  parameter int W  = 32,
  parameter int DW = 16
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [DW-1:0]  d,
  input  logic [1:0]     op,
  output logic           is_mul,
  output logic [W-1:0]   lin_res,
  output logic [2*W-1:0] prod
);
  localparam int PW = 2 * W;

  logic [W:0]   m_ext;
  logic [W:0]   sum_u, sum_v, diff, wrap;
  logic [W-1:0] add_r, sub_r;

  always_comb begin
    m_ext = {1'b1, {W{1'b0}}} - {{(W+1-DW){1'b0}}, d};
    // addition: both candidates every time, then pick
    sum_u = {1'b0, a} + {1'b0, b};
    sum_v = sum_u - m_ext;
    add_r = (sum_u >= m_ext) ? sum_v[W-1:0] : sum_u[W-1:0];
    // subtraction: raw difference and difference plus m in parallel
    diff  = {1'b0, a} - {1'b0, b};
    wrap  = diff + m_ext;
    sub_r = diff[W] ? wrap[W-1:0] : diff[W-1:0];
    lin_res = op[0] ? sub_r : add_r;
    is_mul  = op[1];
    prod    = {{(PW-W){1'b0}}, a} * {{(PW-W){1'b0}}, b};
  end
endmodule

// File: rtl/pmr_fold.sv
// Stage-2 reduction of a double-width product modulo 2^W - d.
module pmr_fold #(
  parameter int W  = 32,
  parameter int DW = 16
) (
  input  logic [2*W-1:0] prod,
  input  logic [DW-1:0]  d,
  output logic [W-1:0]   res
);
  localparam int TW = W + DW;   // width of ph * d
  localparam int FW = 2 * DW;   // width of uh * d
  localparam int SW = W + 2;    // width of the folded sum

  logic [W-1:0]  ph, pl, ul;
  logic [TW-1:0] t1;
  logic [DW-1:0] uh;
  logic [FW-1:0] t2;
  logic [SW-1:0] s, m_s, m2_s, c1, c2;

  always_comb begin
    ph = prod[2*W-1:W];
    pl = prod[W-1:0];
    // first fold: high word times d
    t1 = {{DW{1'b0}}, ph} * {{W{1'b0}}, d};
    uh = t1[TW-1:W];
    ul = t1[W-1:0];
    // second fold: remaining high part times d
    t2 = {{DW{1'b0}}, uh} * {{DW{1'b0}}, d};
    s  = {{(SW-FW){1'b0}}, t2} + {2'b00, ul} + {2'b00, pl};
    m_s  = {2'b01, {W{1'b0}}} - {{(SW-DW){1'b0}}, d};
    m2_s = {m_s[SW-2:0], 1'b0};
    c1 = s - m_s;
    c2 = s - m2_s;
    if (s >= m2_s)     res = c2[W-1:0];
    else if (s >= m_s) res = c1[W-1:0];
    else               res = s[W-1:0];
  end
endmodule

// File: rtl/pmr_unit.sv
module pmr_unit #(
  parameter int W  = 32,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    in_op,
  input  logic [W-1:0]  in_a,
  input  logic [W-1:0]  in_b,
  input  logic [DW-1:0] in_d,
  output logic          out_valid,
  output logic [W-1:0]  out_data
);
  logic           p_mul;
  logic [W-1:0]   p_lin;
  logic [2*W-1:0] p_prod;

  logic           s1_valid, s1_mul;
  logic [W-1:0]   s1_lin;
  logic [2*W-1:0] s1_prod;
  logic [DW-1:0]  s1_d;
  logic [W-1:0]   f_res;

  pmr_prep #(.W(W), .DW(DW)) u_prep (
    .a(in_a), .b(in_b), .d(in_d), .op(in_op),
    .is_mul(p_mul), .lin_res(p_lin), .prod(p_prod)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_mul   <= 1'b0;
      s1_lin   <= '0;
      s1_prod  <= '0;
      s1_d     <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_mul  <= p_mul;
        s1_lin  <= p_lin;
        s1_prod <= p_prod;
        s1_d    <= in_d;
      end
    end
  end

  pmr_fold #(.W(W), .DW(DW)) u_fold (
    .prod(s1_prod), .d(s1_d), .res(f_res)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) out_data <= s1_mul ? f_res : s1_lin;
    end
  end
endmodule

// File: rtl/pmr_unit_chk.sv
module pmr_unit_chk #(
  parameter int W  = 32,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [1:0]    in_op,
  input logic [W-1:0]  in_a,
  input logic [W-1:0]  in_b,
  input logic [DW-1:0] in_d,
  input logic          out_valid,
  input logic [W-1:0]  out_data
);
  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_data == '0));

  a_r2_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);

  a_r10_idle_gap: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);

  a_r6_below_modulus: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ({1'b0, out_data} <
                   ({1'b1, {W{1'b0}}} - {{(W+1-DW){1'b0}}, $past(in_d, 2)})));

  a_r3_add_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'b00 && in_b == '0) |-> ##2 (out_data == $past(in_a, 2)));

  a_r4_sub_self: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'b01 && in_a == in_b) |-> ##2 (out_data == '0));

  a_r5_mul_one: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op[1] && in_b == W'(1)) |-> ##2 (out_data == $past(in_a, 2)));
endmodule

bind pmr_unit pmr_unit_chk #(.W(W), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
  .in_a(in_a), .in_b(in_b), .in_d(in_d),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/pmr_unit_bench.sv
module pmr_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_op = 2'b00;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic [15:0] in_d = 16'd5;
  logic        out_valid;
  logic [31:0] out_data;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    logic [31:0]     data;
    longint unsigned m;
    int              cyc;
    string           tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;   // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  pmr_unit u_pmr_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .in_d(in_d),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [31:0] model(input logic [1:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [15:0] d);
    longint unsigned m, x, y;
    m = 64'h1_0000_0000 - longint'(d);
    x = longint'(a);
    y = longint'(b);
    if (op[1])       return 32'((x * y) % m);
    else if (op[0])  return 32'((x + m - y) % m);
    else             return 32'((x + y) % m);
  endfunction

  task automatic check(input bit ok, input string req, input longint unsigned act,
                       input longint unsigned expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] d, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_d = d;
    e.data = model(op, a, b, d);
    e.m    = 64'h1_0000_0000 - longint'(d);
    e.cyc  = cyc;
    e.tag  = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_a = $urandom; in_b = $urandom;
    end
  endtask

  // monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R2 unexpected result", out_data, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(out_data == e.data, e.tag, out_data, e.data);
          check(longint'(out_data) < e.m, "R6 bound", out_data, e.m);
          check(cyc - e.cyc == 2, "R2 latency", cyc - e.cyc, 2);
        end
      end else if (sb.size() > 0) begin
        check(cyc - sb[0].cyc < 2, "R10 missing result", cyc - sb[0].cyc, 2);
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [15:0] dl [5] = '{16'd5, 16'd189, 16'd65534, 16'd1, 16'd40000};
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && out_data == '0, "R1 in reset", {out_valid, out_data}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && out_data == '0, "R1 after reset", {out_valid, out_data}, 0);

    foreach (dl[k]) begin
      logic [15:0] d;
      logic [31:0] mx;
      d  = dl[k];
      mx = 32'(64'h1_0000_0000 - longint'(d) - 1);
      // R8: first op under a new d follows the previous d back to back
      issue(2'b10, mx, mx - 1, d, "R8 d switch");
      issue(2'b00, mx, mx, d, "R3 max+max");
      issue(2'b00, 0, 0, d, "R3 zero");
      issue(2'b00, mx, 1, d, "R3 wrap to 0");
      issue(2'b00, mx, 0, d, "R3 add zero");
      issue(2'b01, 0, mx, d, "R4 0-max");
      issue(2'b01, mx, mx, d, "R4 self");
      issue(2'b01, 0, 0, d, "R4 zero");
      issue(2'b10, mx, mx, d, "R5 max*max");
      issue(2'b10, mx, 1, d, "R5 times one");
      issue(2'b10, 0, mx, d, "R5 zero");
      issue(2'b11, mx, mx - 7, d, "R7 alias 11");
      issue(2'b11, 32'h1234_5678, mx, d, "R7 alias 11");
      idle(1);
      for (int i = 0; i < 250; i++) begin
        logic [1:0]  op;
        logic [31:0] a, b;
        string t;
        op = 2'($urandom);
        a  = 32'(longint'($urandom) % (longint'(mx) + 1));
        b  = 32'(longint'($urandom) % (longint'(mx) + 1));
        if (op == 2'b11)      t = "R7 random";
        else if (op == 2'b10) t = "R5 random";
        else if (op == 2'b01) t = "R4 random";
        else                  t = "R3 random";
        if (i % 40 < 20) t = {t, " R9 burst"};
        issue(op, a, b, d, t);
        if (i % 40 >= 20 && ($urandom % 5) == 0) idle(1 + ($urandom % 3));
      end
    end
    idle(5);
    check(sb.size() == 0, "R2 all results", sb.size(), 0);
    finish_run();
  end
endmodule